// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is a slave on a three-wire synchronous serial link: a serial clock, a framing enable and a data line. While the enable is high, the block shifts in a 16-bit control word, most significant bit first, on each rising edge of the serial clock. When the enable falls, the block checks that exactly 16 bits arrived. If so, it writes the 11-bit payload into one of two configuration registers. A single address bit, placed directly above the payload, selects which register is written. Frames of any other length are dropped.

The two registers are a motor mode register and a data select register. Their contents are exported as whole words and as decoded fields, for use by the speed-control, braking and PWM logic elsewhere on the chip. The block also drives two status outputs:
- a transfer-complete flag, which shows that a full 16-bit word has been shifted in;
- a standby flag, derived from the mode register.

The serial pins are asynchronous to the system clock. Each pin passes through a multi-stage synchronizer, and all edges are detected in the system clock domain.

Top module: `ser_cfg_port`

## Requirements
- R1: After reset, both registers read zero, standby_o is 1 and done_o is 0.
- R2: While ser_en_i is high, each rising edge of ser_clk_i shifts in ser_dat_i. The first bit is frame bit 15 and the last bit is frame bit 0. The payload is frame bits 10..0.
- R3: Frame bit 11 is the address bit. When it is 1, the payload goes to the mode register. When it is 0, the payload goes to the data register. The other register is left unchanged.
- R4: Frame bits 15..12 are header bits and have no effect on either register.
- R5: A frame with fewer than 16 or more than 16 serial clock rising edges is discarded, and both registers keep their values.
- R6: A word is written only on the falling edge of ser_en_i. While the enable stays high, the registers do not change, even after 16 bits have arrived.
- R7: done_o goes high once exactly 16 bits have been shifted. It stays high until the next rising edge of the enable. A 17th bit clears it.
- R8: The mode fields are taken from the mode register as follows:
  - motor_on_o: bit 0
  - brake_sel_o: bits 2..1
  - duty_full_o: bit 3
  - ready_narrow_o: bit 4
  - osp_en_o: bit 5
  - iref_sel_o: bits 7..6
  - mask_long_o: bit 8
  - freq_only_o: bit 9
  - dir_rev_o: bit 10
- R9: The data fields are taken from the data register as follows:
  - mr_div_o: bits 1..0
  - osc_div_o: bits 3..2
  - pll_sel_o: bits 5..4
  - pre_step_o: bits 8..6
  - pwm_mult_o: bits 10..9
- R10: standby_o is 1 exactly when mode bits 0, 1 and 2 are all zero.
- R11: Serial clock edges while ser_en_i is low shift nothing and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_en_i | input | 1 | Frame enable, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| done_o | output | 1 | Transfer complete, 16 bits received |
| standby_o | output | 1 | Motor, brake1 and brake2 bits all zero |
| mode_word_o | output | 11 | Mode register contents |
| data_word_o | output | 11 | Data register contents |
| motor_on_o | output | 1 | Motor run request |
| brake_sel_o | output | 2 | Brake mode code |
| duty_full_o | output | 1 | Full duty enable |
| ready_narrow_o | output | 1 | Narrow ready window select |
| osp_en_o | output | 1 | Overshoot prevention enable |
| iref_sel_o | output | 2 | Current reference scale code |
| mask_long_o | output | 1 | Long current-sense mask |
| freq_only_o | output | 1 | Frequency-only control method |
| dir_rev_o | output | 1 | Direction select |
| mr_div_o | output | 2 | Speed signal divisor code |
| osc_div_o | output | 2 | Oscillator divisor code |
| pll_sel_o | output | 2 | Phase output ratio and pump selects |
| pre_step_o | output | 3 | Precharge step code |
| pwm_mult_o | output | 2 | PWM frequency multiplier code |

## Verification
The test words are asymmetric (0x5A5 for the mode register, 0x3C6 for the data register). A bit-order or field-offset error therefore shows up as a wrong field value rather than a matching one. One data frame carries nonzero header bits, to show that only bit 11 steers the write. Frames of 15 and 17 bits confirm that only exact-length words commit. They also show how done_o behaves in each case. A frame held open after its 16th bit separates commit-on-enable-fall from commit-on-count. Three mode words (all zero, brake-only, motor-only) exercise each term of the standby decode. Serial clock pulses sent with the enable low show that idle activity on the link cannot disturb the stored state.

// File: rtl/scp_pkg.sv
package scp_pkg;

  typedef enum logic [1:0] {
    BRK_NONE  = 2'd0,
    BRK_PLUG  = 2'd1,
    BRK_MIXED = 2'd2,
    BRK_REGEN = 2'd3
  } brake_e;

  typedef struct packed {
    logic       dir_rev;
    logic       freq_only;
    logic       mask_long;
    logic [1:0] iref_sel;
    logic       osp_en;
    logic       ready_narrow;
    logic       duty_full;
    brake_e     brake;
    logic       motor_on;
  } mode_fields_t;

  typedef struct packed {
    logic [1:0] pwm_mult;
    logic [2:0] pre_step;
    logic [1:0] pll_sel;
    logic [1:0] osc_div;
    logic [1:0] mr_div;
  } data_fields_t;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= d_i;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= '0;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign lvl_o  = pipe[STAGES-1];
  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall_o = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_lvl,
  input  logic               en_rise,
  input  logic               en_fall,
  input  logic               sck_rise,
  input  logic               din,
  output logic [FRAME_W-1:0] word_o,
  output logic               done_o,
  output logic               commit_o
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  logic [CW-1:0]      cnt;
  logic [FRAME_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sh     <= '0;
      done_o <= 1'b0;
    end else if (en_rise) begin
      cnt    <= '0;
      done_o <= 1'b0;
    end else if (en_lvl && sck_rise) begin
      sh     <= {sh[FRAME_W-2:0], din};
      if (cnt != CW'(CNT_MAX)) cnt <= cnt + 1'b1;
      done_o <= (cnt == CW'(FRAME_W - 1));
    end
  end

  assign word_o   = sh;
  assign commit_o = en_fall && (cnt == CW'(FRAME_W));

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(CNT_MAX)); // R5

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (cnt == '0) && !done_o); // R7

endmodule

// File: rtl/scp_bank.sv
module scp_bank #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (wr_i) q_o <= d_i;
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(q_o)); // R3

endmodule

// File: rtl/ser_cfg_port.sv
module ser_cfg_port #(
  parameter int FRAME_W     = 16,
  parameter int PAY_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             ser_en_i,
  input  logic             ser_dat_i,
  output logic             done_o,
  output logic             standby_o,
  output logic [PAY_W-1:0] mode_word_o,
  output logic [PAY_W-1:0] data_word_o,
  output logic             motor_on_o,
  output logic [1:0]       brake_sel_o,
  output logic             duty_full_o,
  output logic             ready_narrow_o,
  output logic             osp_en_o,
  output logic [1:0]       iref_sel_o,
  output logic             mask_long_o,
  output logic             freq_only_o,
  output logic             dir_rev_o,
  output logic [1:0]       mr_div_o,
  output logic [1:0]       osc_div_o,
  output logic [1:0]       pll_sel_o,
  output logic [2:0]       pre_step_o,
  output logic [1:0]       pwm_mult_o
);
  import scp_pkg::*;

  localparam int ADDR_BIT = PAY_W;
  localparam int PIN_N    = 3;
  localparam int P_CLK    = 0;
  localparam int P_EN     = 1;
  localparam int P_DAT    = 2;

  logic [PIN_N-1:0]   pin_lvl, pin_rise, pin_fall;
  logic [FRAME_W-1:0] word;
  logic               commit, wr_mode, wr_data;
  logic [PAY_W-1:0]   mode_q, data_q;
  mode_fields_t       mf;
  data_fields_t       df;

  scp_sync #(.W(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d_i    ({ser_dat_i, ser_en_i, ser_clk_i}),
    .lvl_o  (pin_lvl),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  scp_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .en_lvl   (pin_lvl[P_EN]),
    .en_rise  (pin_rise[P_EN]),
    .en_fall  (pin_fall[P_EN]),
    .sck_rise (pin_rise[P_CLK]),
    .din      (pin_lvl[P_DAT]),
    .word_o   (word),
    .done_o   (done_o),
    .commit_o (commit)
  );

  assign wr_mode = commit &&  word[ADDR_BIT];
  assign wr_data = commit && !word[ADDR_BIT];

  scp_bank #(.W(PAY_W)) u_mode (
    .clk  (clk),
    .rst  (rst),
    .wr_i (wr_mode),
    .d_i  (word[PAY_W-1:0]),
    .q_o  (mode_q)
  );

  scp_bank #(.W(PAY_W)) u_data (
    .clk  (clk),
    .rst  (rst),
    .wr_i (wr_data),
    .d_i  (word[PAY_W-1:0]),
    .q_o  (data_q)
  );

  assign mf = mode_fields_t'(mode_q);
  assign df = data_fields_t'(data_q);

  assign mode_word_o    = mode_q;
  assign data_word_o    = data_q;
  assign motor_on_o     = mf.motor_on;
  assign brake_sel_o    = mf.brake;
  assign duty_full_o    = mf.duty_full;
  assign ready_narrow_o = mf.ready_narrow;
  assign osp_en_o       = mf.osp_en;
  assign iref_sel_o     = mf.iref_sel;
  assign mask_long_o    = mf.mask_long;
  assign freq_only_o    = mf.freq_only;
  assign dir_rev_o      = mf.dir_rev;
  assign mr_div_o       = df.mr_div;
  assign osc_div_o      = df.osc_div;
  assign pll_sel_o      = df.pll_sel;
  assign pre_step_o     = df.pre_step;
  assign pwm_mult_o     = df.pwm_mult;
  assign standby_o      = !mf.motor_on && (mf.brake == BRK_NONE);

  AST_WR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    (wr_mode || wr_data) |-> done_o); // R6

  AST_STBY_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> standby_o && !done_o); // R1

endmodule

// File: tb/ser_cfg_port_tb_top.sv
module ser_cfg_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, sen = 1'b0, sdat = 1'b0;

  logic        done, stby;
  logic [10:0] mword, dword;
  logic        mon, duty, rdy, osp, mask, fonly, dir;
  logic [1:0]  brk, iref, mrd, oscd, plls, pwmm;
  logic [2:0]  pre;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ser_cfg_port dut_i (
    .clk(clk), .rst(rst),
    .ser_clk_i(sck), .ser_en_i(sen), .ser_dat_i(sdat),
    .done_o(done), .standby_o(stby),
    .mode_word_o(mword), .data_word_o(dword),
    .motor_on_o(mon), .brake_sel_o(brk), .duty_full_o(duty),
    .ready_narrow_o(rdy), .osp_en_o(osp), .iref_sel_o(iref),
    .mask_long_o(mask), .freq_only_o(fonly), .dir_rev_o(dir),
    .mr_div_o(mrd), .osc_div_o(oscd), .pll_sel_o(plls),
    .pre_step_o(pre), .pwm_mult_o(pwmm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [16:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdat = w[i];
      wait_clk(4);
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
    wait_clk(6);
  endtask

  task automatic open_frame();
    sen = 1'b1;
    wait_clk(6);
  endtask

  task automatic close_frame();
    sen = 1'b0;
    wait_clk(8);
  endtask

  task automatic send(input logic [16:0] w, input int nbits);
    open_frame();
    shift_bits(w, nbits);
    close_frame();
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(mword), 0);
    chk("R1 data", 32'(dword), 0);
    chk("R1 standby", 32'(stby), 1);
    chk("R1 done", 32'(done), 0);
  endtask

  task automatic t_mode_write();
    send({1'b0, 4'h0, 1'b1, 11'h5A5}, 16);
    chk("R2 R3 mode word", 32'(mword), 32'h5A5);
    chk("R3 data untouched", 32'(dword), 0);
    chk("R8 motor", 32'(mon), 1);
    chk("R8 brake", 32'(brk), 2);
    chk("R8 duty", 32'(duty), 0);
    chk("R8 ready", 32'(rdy), 0);
    chk("R8 osp", 32'(osp), 1);
    chk("R8 iref", 32'(iref), 2);
    chk("R8 mask", 32'(mask), 1);
    chk("R8 freq only", 32'(fonly), 0);
    chk("R8 dir", 32'(dir), 1);
    chk("R10 not standby", 32'(stby), 0);
  endtask

  task automatic t_data_write();
    send({1'b0, 4'hB, 1'b0, 11'h3C6}, 16);
    chk("R3 R4 data word", 32'(dword), 32'h3C6);
    chk("R3 mode untouched", 32'(mword), 32'h5A5);
    chk("R9 mr div", 32'(mrd), 2);
    chk("R9 osc div", 32'(oscd), 1);
    chk("R9 pll sel", 32'(plls), 0);
    chk("R9 pre step", 32'(pre), 7);
    chk("R9 pwm mult", 32'(pwmm), 1);
  endtask

  task automatic t_bad_length();
    open_frame();
    shift_bits({2'b0, 4'h0, 1'b1, 10'h001}, 15);
    chk("R7 done low short", 32'(done), 0);
    close_frame();
    chk("R5 short mode kept", 32'(mword), 32'h5A5);
    open_frame();
    shift_bits({1'b1, 4'h0, 1'b0, 11'h000}, 16);
    chk("R7 done at 16", 32'(done), 1);
    shift_bits(17'h1, 1);
    chk("R7 done cleared by 17th", 32'(done), 0);
    close_frame();
    chk("R5 long data kept", 32'(dword), 32'h3C6);
    chk("R5 long mode kept", 32'(mword), 32'h5A5);
  endtask

  task automatic t_commit_on_fall();
    open_frame();
    shift_bits({1'b0, 4'h0, 1'b1, 11'h000}, 16);
    chk("R6 held while enabled", 32'(mword), 32'h5A5);
    chk("R7 done held", 32'(done), 1);
    close_frame();
    chk("R6 written on fall", 32'(mword), 0);
    chk("R10 standby all zero", 32'(stby), 1);
    chk("R7 done kept until next start", 32'(done), 1);
    open_frame();
    chk("R7 done cleared at start", 32'(done), 0);
    shift_bits({1'b0, 4'h0, 1'b1, 11'h004}, 16);
    close_frame();
    chk("R10 brake only", 32'(stby), 0);
    send({1'b0, 4'h0, 1'b1, 11'h001}, 16);
    chk("R10 motor only", 32'(stby), 0);
  endtask

  task automatic t_idle_clocks();
    shift_bits({1'b0, 16'hFFFF}, 16);
    chk("R11 mode unchanged", 32'(mword), 32'h001);
    chk("R11 data unchanged", 32'(dword), 32'h3C6);
    send({1'b0, 4'h0, 1'b0, 11'h155}, 16);
    chk("R11 next frame aligned", 32'(dword), 32'h155);
  endtask

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    t_reset();
    t_mode_write();
    t_data_write();
    t_bad_length();
    t_commit_on_fall();
    t_idle_clocks();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule